// File: doc/BRIEF.md
# Port device select decoder

This block turns an 8-bit port address, a memory-or-I/O status line and the active-low read and write strobes into active-low device select lines for input ports and output ports. A select is a pulse: it is low only while the status line marks an I/O cycle and the strobe for its direction is low, and the address matches that port. The input selects are meant to enable the tri-state drivers of input ports. The output selects are meant to load the latches of output ports. The buffers and latches are not part of this block.

A parameter picks how the address is decoded. In single-port mode the address is ignored and the gated strobes are the only selects. In linear mode each address bit owns one port. In quad mode only the two lowest address bits are decoded, so many port numbers land on the same select. In full mode every address has its own select, built from 1-of-8 stages that have enable gating. The block also has a flag that goes high when two or more input selects are low at once, which would mean contention on the data bus. Every output is combinational.

Top module: `port_sel_decoder`

## Requirements
- R1: Every input select (`in_sel_n`) is high unless `io_sel` is 1 and `rd_n` is 0 at the same time.
- R2: Every output select (`out_sel_n`) is high unless `io_sel` is 1 and `wr_n` is 0 at the same time.
- R3: In linear mode (8 selects per direction), bit i of a select vector is low exactly when its strobe is gated active and `port_addr[i]` is 1.
- R4: In linear mode, an address with several bits set selects several ports at once. Example: address 0x0C with a read pulls `in_sel_n` bits 2 and 3 low (0xF3).
- R5: `bus_clash` is 1 whenever two or more bits of `in_sel_n` are low, and 0 otherwise. Output selects never raise it.
- R6: In quad mode (4 selects per direction), `port_addr[7:2]` has no effect. Addresses 0x05 and 0xF1 both choose select 1.
- R7: In quad and full modes, at most one select of a direction is low at a time. When its strobe is active, that select is the one at index `port_addr[1:0]` (quad) or `port_addr` (full).
- R8: In full mode (256 selects per direction, 512 in all), only `in_sel_n[port_addr]` or `out_sel_n[port_addr]` goes low. Each 1-of-8 stage holds all its outputs high unless its enable condition is met.
- R9: In single-port mode (1 select per direction), the address is ignored. `in_sel_n[0]` is low exactly for a gated read, and `out_sel_n[0]` is low exactly for a gated write.
- R10: The outputs are combinational. They follow input changes with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_sel | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| port_addr | input | ADDR_W (8) | Port address |
| in_sel_n | output | NSEL | Active-low input port selects (1, 8, 4 or 256 by mode) |
| out_sel_n | output | NSEL | Active-low output port selects |
| bus_clash | output | 1 | High when more than one input select is low |

## Verification
The checker tests a set of properties on every input change. Both select vectors must stay high outside a gated I/O strobe. The clash flag must agree with the number of low input selects. In linear mode a low select must always have its address bit set. In the decoded modes no more than one select may be low. Other behaviours can only be shown by the bench's scenarios with known answers. These are that the right port is chosen for a given address, that addresses fold back onto the same select in quad mode, that a single-port build ignores the address, and that the outputs react to input changes made between clock edges.

// File: rtl/pds_pkg.sv
// Package: shared types for the port device select decoder.
// Assumes ADDR_W >= 3, so that full mode can be built from 1-of-8 stages.
package pds_pkg;

    typedef enum logic [1:0] {
        SEL_SINGLE = 2'd0,
        SEL_LINEAR = 2'd1,
        SEL_QUAD   = 2'd2,
        SEL_FULL   = 2'd3
    } sel_mode_e;

    // Number of select lines per direction for a decode mode.
    function automatic int sel_count(sel_mode_e m, int addr_w);
        case (m)
            SEL_SINGLE: return 1;
            SEL_LINEAR: return addr_w;
            SEL_QUAD:   return 4;
            default:    return 1 << addr_w;
        endcase
    endfunction

endpackage

// File: rtl/pds_oct_stage.sv
// Module: 1-of-8 decode stage with two active-low enables and one active-high enable.
// Assumes nothing about input timing. When the enable condition is not met, all outputs stay high.
module pds_oct_stage (
    input  logic       en_hi,
    input  logic       en_a_n,
    input  logic       en_b_n,
    input  logic [2:0] sel,
    output logic [7:0] y_n
);
    logic active;

    // Enable gating: active only with both low enables low and the high enable high.
    always_comb active = en_hi & ~en_a_n & ~en_b_n;

    // One-cold output: only the line picked by sel drops.
    always_comb begin
        for (int k = 0; k < 8; k++) begin
            y_n[k] = ~(active && (sel == 3'(k)));
        end
    end
endmodule

// File: rtl/pds_sel_decoder.sv
// Module: builds one direction's active-low select vector from the status line,
// that direction's strobe and the port address. MODE picks the decode style.
// Assumes NSEL matches pds_pkg::sel_count(MODE, ADDR_W).
module pds_sel_decoder #(
    parameter pds_pkg::sel_mode_e MODE = pds_pkg::SEL_LINEAR,
    parameter int ADDR_W = 8,
    parameter int NSEL   = pds_pkg::sel_count(MODE, ADDR_W)
) (
    input  logic              io_sel,
    input  logic              strb_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [NSEL-1:0]   sel_n
);
    localparam int HI_W    = ADDR_W - 3;
    localparam int NSTAGE  = 1 << HI_W;

    if (MODE == pds_pkg::SEL_FULL) begin : g_full
        // Full decode: bank of 1-of-8 stages; the upper address bits pick a stage.
        for (genvar j = 0; j < NSTAGE; j++) begin : g_stage
            logic hit;
            // Stage enable: the upper address bits equal this stage's number.
            always_comb hit = (addr[ADDR_W-1:3] == HI_W'(j));
            pds_oct_stage u_stage (
                .en_hi  (hit),
                .en_a_n (strb_n),
                .en_b_n (~io_sel),
                .sel    (addr[2:0]),
                .y_n    (sel_n[j*8 +: 8])
            );
        end
    end else begin : g_gated
        logic go;
        // Gated strobe: an I/O cycle with this direction's strobe low.
        always_comb go = io_sel & ~strb_n;

        if (MODE == pds_pkg::SEL_LINEAR) begin : g_linear
            // Linear selection: each address bit owns one select.
            always_comb sel_n = ~({NSEL{go}} & addr);
        end else if (MODE == pds_pkg::SEL_QUAD) begin : g_quad
            // Quad decode: only the two lowest address bits count.
            always_comb begin
                for (int k = 0; k < 4; k++) begin
                    sel_n[k] = ~(go && (addr[1:0] == 2'(k)));
                end
            end
        end else begin : g_single
            // Single port: the gated strobe is the select; the address is ignored.
            always_comb sel_n = ~go;
        end
    end
endmodule

// File: rtl/pds_clash_detect.sv
// Module: raises a flag when more than one active-low input select is low.
// Assumes a select vector of any width, 1 or more.
module pds_clash_detect #(
    parameter int NSEL = 8
) (
    input  logic [NSEL-1:0] sel_n,
    output logic            clash
);
    logic [NSEL-1:0] act;

    // Clearing the lowest set bit leaves something only when two or more bits are set.
    always_comb begin
        act   = ~sel_n;
        clash = |(act & (act - NSEL'(1)));
    end
endmodule

// File: rtl/port_sel_decoder.sv
// Module: top of the port device select decoder. Produces the input and output
// select vectors and the input bus contention flag. Purely combinational: no clock, no state.
module port_sel_decoder #(
    parameter pds_pkg::sel_mode_e MODE = pds_pkg::SEL_LINEAR,
    parameter int ADDR_W = 8,
    parameter int NSEL   = pds_pkg::sel_count(MODE, ADDR_W)
) (
    input  logic              io_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] port_addr,
    output logic [NSEL-1:0]   in_sel_n,
    output logic [NSEL-1:0]   out_sel_n,
    output logic              bus_clash
);
    // Input direction decode, driven by the read strobe.
    pds_sel_decoder #(.MODE(MODE), .ADDR_W(ADDR_W), .NSEL(NSEL)) u_in_dec (
        .io_sel (io_sel),
        .strb_n (rd_n),
        .addr   (port_addr),
        .sel_n  (in_sel_n)
    );

    // Output direction decode, driven by the write strobe.
    pds_sel_decoder #(.MODE(MODE), .ADDR_W(ADDR_W), .NSEL(NSEL)) u_out_dec (
        .io_sel (io_sel),
        .strb_n (wr_n),
        .addr   (port_addr),
        .sel_n  (out_sel_n)
    );

    // Contention watch on the input side only.
    pds_clash_detect #(.NSEL(NSEL)) u_clash (
        .sel_n (in_sel_n),
        .clash (bus_clash)
    );
endmodule

// File: rtl/port_sel_checker.sv
// Module: assertion checker for port_sel_decoder, attached with bind.
// The block is combinational, so the checks are immediate and are skipped while any input is unknown.
module port_sel_checker #(
    parameter pds_pkg::sel_mode_e MODE = pds_pkg::SEL_LINEAR,
    parameter int ADDR_W = 8,
    parameter int NSEL   = pds_pkg::sel_count(MODE, ADDR_W)
) (
    input logic              io_sel,
    input logic              rd_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] port_addr,
    input logic [NSEL-1:0]   in_sel_n,
    input logic [NSEL-1:0]   out_sel_n,
    input logic              bus_clash
);
    logic known;

    // Inputs known: the checks apply only once the inputs are driven.
    always_comb known = !$isunknown({io_sel, rd_n, wr_n, port_addr});

    // Checks that apply in every mode.
    always_comb begin
        if (known) begin
            AST_IN_IDLE: assert (!(io_sel && !rd_n) -> (&in_sel_n)) else $error("input select outside read");   // R1
            AST_OUT_IDLE: assert (!(io_sel && !wr_n) -> (&out_sel_n)) else $error("output select outside write"); // R2
            AST_CLASH_MATCH: assert (bus_clash == ($countones(~in_sel_n) > 1)) else $error("clash flag wrong"); // R5
        end
    end

    if (MODE == pds_pkg::SEL_LINEAR) begin : g_lin_chk
        // Linear: a low select always has its address bit set.
        always_comb begin
            if (known) begin
                AST_LINEAR_BIT: assert (((~in_sel_n | ~out_sel_n) & ~port_addr) == '0) else $error("select without address bit"); // R3
            end
        end
    end else if (MODE != pds_pkg::SEL_SINGLE) begin : g_dec_chk
        // Decoded modes: no more than one select low per direction.
        always_comb begin
            if (known) begin
                AST_ONE_COLD: assert ($onehot0(~in_sel_n) && $onehot0(~out_sel_n)) else $error("several decoded selects"); // R7
            end
        end
    end
endmodule

bind port_sel_decoder port_sel_checker #(.MODE(MODE), .ADDR_W(ADDR_W), .NSEL(NSEL)) u_chk (
    .io_sel    (io_sel),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .port_addr (port_addr),
    .in_sel_n  (in_sel_n),
    .out_sel_n (out_sel_n),
    .bus_clash (bus_clash)
);

// File: tb/sim_port_sel_decoder.sv
// Bench: one instance per decode mode; linear mode is walked through a vector table,
// then directed tests cover the other modes and the corner cases.
module sim_port_sel_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_sel = 1'b0;
    logic rd_n = 1'b1;
    logic wr_n = 1'b1;
    logic [7:0] port_addr = 8'h00;

    logic [7:0]   lin_in, lin_out;
    logic [3:0]   qd_in, qd_out;
    logic [255:0] fl_in, fl_out;
    logic [0:0]   sg_in, sg_out;
    logic lin_clash, qd_clash, fl_clash, sg_clash;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    port_sel_decoder #(.MODE(pds_pkg::SEL_LINEAR)) u0 (
        .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n), .port_addr(port_addr),
        .in_sel_n(lin_in), .out_sel_n(lin_out), .bus_clash(lin_clash));
    port_sel_decoder #(.MODE(pds_pkg::SEL_QUAD)) u1 (
        .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n), .port_addr(port_addr),
        .in_sel_n(qd_in), .out_sel_n(qd_out), .bus_clash(qd_clash));
    port_sel_decoder #(.MODE(pds_pkg::SEL_FULL)) u2 (
        .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n), .port_addr(port_addr),
        .in_sel_n(fl_in), .out_sel_n(fl_out), .bus_clash(fl_clash));
    port_sel_decoder #(.MODE(pds_pkg::SEL_SINGLE)) u3 (
        .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n), .port_addr(port_addr),
        .in_sel_n(sg_in), .out_sel_n(sg_out), .bus_clash(sg_clash));

    // Vector: io, rd_n, wr_n, addr, expected in, expected out, expected clash.
    typedef struct packed {
        logic       io;
        logic       rd;
        logic       wr;
        logic [7:0] addr;
        logic [7:0] ein;
        logic [7:0] eout;
        logic       eclash;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b1, 8'h10, 8'hFF, 8'hFF, 1'b0},  // memory read: no select (R1)
        '{1'b1, 1'b0, 1'b1, 8'h10, 8'hEF, 8'hFF, 1'b0},  // read port 4 (R3)
        '{1'b1, 1'b1, 1'b0, 8'h80, 8'hFF, 8'h7F, 1'b0},  // write port 7 (R3, R2)
        '{1'b1, 1'b0, 1'b1, 8'h0C, 8'hF3, 8'hFF, 1'b1},  // two inputs at once (R4, R5)
        '{1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0},  // no strobe (R1, R2)
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 8'hFF, 1'b0},  // read, no bit set (R3)
        '{1'b1, 1'b1, 1'b0, 8'h0C, 8'hFF, 8'hF3, 1'b0},  // two outputs: no clash (R5)
        '{1'b0, 1'b1, 1'b0, 8'h01, 8'hFF, 8'hFF, 1'b0}   // memory write: no select (R2)
    };

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive inputs halfway between clock edges, then sample 1 ns later.
    task automatic drive(input logic io, input logic r, input logic w, input logic [7:0] a);
        @(negedge clk);
        io_sel = io; rd_n = r; wr_n = w; port_addr = a;
        #1;
    endtask

    function automatic logic [255:0] full_exp(input logic [7:0] a);
        logic [255:0] v = '1;
        v[a] = 1'b0;
        return v;
    endfunction

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Idle state while the bench reset is held (R1, R2).
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset idle in", 256'(lin_in), 256'(8'hFF));
        chk("R2 reset idle out", 256'(lin_out), 256'(8'hFF));
        chk("R5 reset clash", 256'(lin_clash), 256'(0));
        rst_n = 1'b1;

        // Linear mode: walk the vector table.
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].io, VECS[i].rd, VECS[i].wr, VECS[i].addr);
            chk($sformatf("R1,R2,R3,R4 linear row %0d in", i), 256'(lin_in), 256'(VECS[i].ein));
            chk($sformatf("R2,R3 linear row %0d out", i), 256'(lin_out), 256'(VECS[i].eout));
            chk($sformatf("R5 linear row %0d clash", i), 256'(lin_clash), 256'(VECS[i].eclash));
        end

        // Quad mode: fold-back of the upper six bits (R6) and one-cold decode (R7).
        drive(1'b1, 1'b0, 1'b1, 8'h05);
        chk("R6 quad 0x05 read", 256'(qd_in), 256'(4'b1101));
        drive(1'b1, 1'b0, 1'b1, 8'hF1);
        chk("R6 quad 0xF1 folds back", 256'(qd_in), 256'(4'b1101));
        chk("R7 quad out idle on read", 256'(qd_out), 256'(4'b1111));
        drive(1'b1, 1'b1, 1'b0, 8'h03);
        chk("R7 quad write index 3", 256'(qd_out), 256'(4'b0111));
        drive(1'b1, 1'b1, 1'b1, 8'h02);
        chk("R7 quad no strobe", 256'({qd_in, qd_out}), 256'(8'hFF));

        // Full mode: exactly the addressed select (R8).
        drive(1'b1, 1'b0, 1'b1, 8'hA7);
        chk("R8 full read 0xA7", fl_in, full_exp(8'hA7));
        chk("R8 full out idle", fl_out, '1);
        drive(1'b1, 1'b1, 1'b0, 8'h00);
        chk("R8 full write 0x00", fl_out, full_exp(8'h00));
        drive(1'b1, 1'b1, 1'b0, 8'hFF);
        chk("R8 full write 0xFF", fl_out, full_exp(8'hFF));
        drive(1'b0, 1'b0, 1'b0, 8'h33);
        chk("R8 full memory cycle", fl_in & fl_out, '1);
        chk("R5 decoded modes no clash", 256'({qd_clash, fl_clash, sg_clash}), 256'(0));

        // Single-port mode: address ignored (R9).
        drive(1'b1, 1'b0, 1'b1, 8'h00);
        chk("R9 single read addr 0x00", 256'({sg_in, sg_out}), 256'(2'b01));
        drive(1'b1, 1'b0, 1'b1, 8'hFF);
        chk("R9 single read addr 0xFF", 256'({sg_in, sg_out}), 256'(2'b01));
        drive(1'b1, 1'b1, 1'b0, 8'h5A);
        chk("R9 single write", 256'({sg_in, sg_out}), 256'(2'b10));
        drive(1'b0, 1'b0, 1'b0, 8'h5A);
        chk("R9 single memory cycle", 256'({sg_in, sg_out}), 256'(2'b11));

        // Combinational response: change inputs just after a rising edge, then sample before the next edge (R10).
        @(posedge clk);
        #0.5;
        io_sel = 1'b1; rd_n = 1'b0; wr_n = 1'b1; port_addr = 8'h02;
        #0.5;
        chk("R10 linear follows without edge", 256'(lin_in), 256'(8'hFD));
        rd_n = 1'b1;
        #0.5;
        chk("R10 strobe release without edge", 256'(lin_in), 256'(8'hFF));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule